// File: doc/BRIEF.md
# Store Access Key Checker

This block sits in front of a memory's write path and decides, for every store, whether the requester may modify the addressed storage. The address space is divided into 2048-byte blocks. Each block owns a 4-bit key, with a value from 0 to 15, held in an internal key table. A requester presents its own 4-bit access key with each store. A CPU store carries the key from its program status word. A channel transfer carries the key that the channel took from the four most significant bits of its channel address word.

A store goes ahead when the access key is zero, or when it equals the addressed block's key. In every other case the store is suppressed, and a protection exception is flagged together with the offending address. Block keys are loaded through a separate key-set port that writes one block key per cycle.

The outputs are registered. Each verdict appears one clock after its request.

Top module: `store_guard`

## Requirements
- R1: After reset, `store_en` and `prot_exc` are 0, `exc_addr` is 0, and every block key is 0.
- R2: A request whose selected access key is 0 yields `store_en`=1 and `prot_exc`=0, whatever the block key.
- R3: A request whose selected access key equals the addressed block key yields `store_en`=1 and `prot_exc`=0.
- R4: A request with a nonzero access key that differs from the block key yields `store_en`=0 and `prot_exc`=1 for that one cycle, with `exc_addr` equal to the request address.
- R5: `req_src`=0 (CPU) selects `cpu_key` as the access key, and `req_src`=1 (channel) selects `chan_key`; the key that is not selected has no effect.
- R6: A key written on `set_valid` is seen by a request in any later cycle. A request in the same cycle as the write still sees the old key.
- R7: The block index is `req_addr[ADDR_W-1:11]`. Address bits 10:0 do not affect the verdict, and the highest block (index all ones) is keyed like any other.
- R8: In a cycle with no request, the next cycle shows `store_en`=0 and `prot_exc`=0.
- R9: Each verdict appears exactly one clock after the request is sampled, never in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_valid | input | 1 | Write a block key this cycle |
| set_block | input | ADDR_W-11 | Index of the block whose key is written |
| set_key | input | KEY_W | New block key |
| req_valid | input | 1 | Store request present |
| req_src | input | 1 | 0 = CPU, 1 = channel |
| cpu_key | input | KEY_W | Access key from the program status word |
| chan_key | input | KEY_W | Access key from the channel address word |
| req_addr | input | ADDR_W | Store byte address |
| store_en | output | 1 | Store permitted (registered) |
| prot_exc | output | 1 | Protection exception, one-cycle pulse |
| exc_addr | output | ADDR_W | Address of the last refused store |

## Verification
A request is driven on a falling edge and captured on the next rising edge. Its `store_en`, `prot_exc` and `exc_addr` are therefore due one edge later, and the bench samples them one nanosecond after that edge. A key write is also captured on that edge, so a request placed in the following vector sees the new key, while a request in the same vector is expected to see the old key. For the latency requirement, the bench also looks at the outputs just after driving a request, before the capturing edge. At that point they must still show the previous verdict.

// File: rtl/store_guard_pkg.sv
package store_guard_pkg;
    localparam int BLK_LSB = 11;   // 2048-byte key granule

    typedef enum logic {
        SRC_CPU  = 1'b0,
        SRC_CHAN = 1'b1
    } req_src_e;
endpackage

// File: rtl/key_table.sv
module key_table #(
    parameter int IDX_W = 9,
    parameter int KEY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [KEY_W-1:0] rd_key
);
    localparam int DEPTH = 1 << IDX_W;

    logic [KEY_W-1:0] keys_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) keys_q[i] <= '0;
        end else if (wr_en) begin
            keys_q[wr_idx] <= wr_key;
        end
    end

    assign rd_key = keys_q[rd_idx];
endmodule

// File: rtl/key_select.sv
module key_select
    import store_guard_pkg::*;
#(
    parameter int KEY_W = 4
) (
    input  req_src_e         src,
    input  logic [KEY_W-1:0] cpu_key,
    input  logic [KEY_W-1:0] chan_key,
    output logic [KEY_W-1:0] acc_key
);
    always_comb begin
        unique case (src)
            SRC_CHAN: acc_key = chan_key;
            default:  acc_key = cpu_key;
        endcase
    end
endmodule

// File: rtl/access_judge.sv
module access_judge #(
    parameter int KEY_W = 4
) (
    input  logic [KEY_W-1:0] acc_key,
    input  logic [KEY_W-1:0] blk_key,
    output logic             grant
);
    logic master;
    logic match;

    assign master = (acc_key == '0);
    assign match  = (acc_key == blk_key);
    assign grant  = master | match;
endmodule

// File: rtl/store_guard.sv
module store_guard
    import store_guard_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int KEY_W  = 4,
    localparam int IDX_W = ADDR_W - BLK_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_valid,
    input  logic [IDX_W-1:0]  set_block,
    input  logic [KEY_W-1:0]  set_key,
    input  logic              req_valid,
    input  logic              req_src,
    input  logic [KEY_W-1:0]  cpu_key,
    input  logic [KEY_W-1:0]  chan_key,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              store_en,
    output logic              prot_exc,
    output logic [ADDR_W-1:0] exc_addr
);
    typedef struct packed {
        logic              en;
        logic              exc;
        logic [ADDR_W-1:0] addr;
    } verdict_t;

    verdict_t         v_d, v_q;
    logic [KEY_W-1:0] acc_key;
    logic [KEY_W-1:0] blk_key;
    logic             grant;
    logic [IDX_W-1:0] blk_idx;

    assign blk_idx = req_addr[ADDR_W-1:BLK_LSB];

    key_table #(.IDX_W(IDX_W), .KEY_W(KEY_W)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (set_valid),
        .wr_idx (set_block),
        .wr_key (set_key),
        .rd_idx (blk_idx),
        .rd_key (blk_key)
    );

    key_select #(.KEY_W(KEY_W)) u_sel (
        .src      (req_src_e'(req_src)),
        .cpu_key  (cpu_key),
        .chan_key (chan_key),
        .acc_key  (acc_key)
    );

    access_judge #(.KEY_W(KEY_W)) u_judge (
        .acc_key (acc_key),
        .blk_key (blk_key),
        .grant   (grant)
    );

    always_comb begin
        v_d     = v_q;
        v_d.en  = 1'b0;
        v_d.exc = 1'b0;
        if (req_valid) begin
            if (grant) begin
                v_d.en = 1'b1;
            end else begin
                v_d.exc  = 1'b1;
                v_d.addr = req_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    assign store_en = v_q.en;
    assign prot_exc = v_q.exc;
    assign exc_addr = v_q.addr;
endmodule

// File: rtl/store_guard_chk.sv
module store_guard_chk #(
    parameter int ADDR_W = 20,
    parameter int KEY_W  = 4,
    localparam int IDX_W = ADDR_W - 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              set_valid,
    input logic [IDX_W-1:0]  set_block,
    input logic [KEY_W-1:0]  set_key,
    input logic              req_valid,
    input logic              req_src,
    input logic [KEY_W-1:0]  cpu_key,
    input logic [KEY_W-1:0]  chan_key,
    input logic [ADDR_W-1:0] req_addr,
    input logic              store_en,
    input logic              prot_exc,
    input logic [ADDR_W-1:0] exc_addr
);
    logic [KEY_W-1:0] sel_key;
    assign sel_key = req_src ? chan_key : cpu_key;

    p_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_en && prot_exc));

    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!store_en && !prot_exc));

    p_zero_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sel_key == '0) |=> (store_en && !prot_exc));

    p_exc_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!prot_exc || exc_addr == $past(req_addr)));

    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && $past(rst_n)) |=> $stable(exc_addr));

    p_one_verdict_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (store_en || prot_exc));
endmodule

bind store_guard store_guard_chk #(.ADDR_W(ADDR_W), .KEY_W(KEY_W)) u_chk (.*);

// File: tb/store_guard_tb_top.sv
module store_guard_tb_top;
    localparam int ADDR_W = 20;
    localparam int KEY_W  = 4;
    localparam int IDX_W  = ADDR_W - 11;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              set_valid;
    logic [IDX_W-1:0]  set_block;
    logic [KEY_W-1:0]  set_key;
    logic              req_valid;
    logic              req_src;
    logic [KEY_W-1:0]  cpu_key;
    logic [KEY_W-1:0]  chan_key;
    logic [ADDR_W-1:0] req_addr;
    logic              store_en;
    logic              prot_exc;
    logic [ADDR_W-1:0] exc_addr;

    int n_checks = 0;
    int n_fails  = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    store_guard #(.ADDR_W(ADDR_W), .KEY_W(KEY_W)) dut_i (.*);

    typedef struct packed {
        logic              sv;
        logic [IDX_W-1:0]  sb;
        logic [KEY_W-1:0]  sk;
        logic              rv;
        logic              src;
        logic [KEY_W-1:0]  ck;
        logic [KEY_W-1:0]  hk;
        logic [ADDR_W-1:0] addr;
        logic              en;
        logic              exc;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 9'd3,   4'd5,  1'b0, 1'b0, 4'd0, 4'd0,  20'h00000, 1'b0, 1'b0}, // R8 set only
        '{1'b0, 9'd0,   4'd0,  1'b1, 1'b0, 4'd5, 4'd0,  20'h01800, 1'b1, 1'b0}, // R3
        '{1'b0, 9'd0,   4'd0,  1'b1, 1'b0, 4'd6, 4'd0,  20'h01FFF, 1'b0, 1'b1}, // R4
        '{1'b0, 9'd0,   4'd0,  1'b1, 1'b0, 4'd0, 4'd7,  20'h01800, 1'b1, 1'b0}, // R2
        '{1'b0, 9'd0,   4'd0,  1'b1, 1'b1, 4'd9, 4'd5,  20'h01900, 1'b1, 1'b0}, // R5 chan
        '{1'b0, 9'd0,   4'd0,  1'b1, 1'b0, 4'd5, 4'd9,  20'h01800, 1'b1, 1'b0}, // R5 cpu
        '{1'b0, 9'd0,   4'd0,  1'b1, 1'b1, 4'd5, 4'd9,  20'h01A00, 1'b0, 1'b1}, // R5 chan refused
        '{1'b0, 9'd0,   4'd0,  1'b1, 1'b0, 4'd5, 4'd0,  20'h02000, 1'b0, 1'b1}, // R7 next block
        '{1'b0, 9'd0,   4'd0,  1'b1, 1'b0, 4'd0, 4'd0,  20'h02000, 1'b1, 1'b0}, // R2
        '{1'b1, 9'd4,   4'd5,  1'b1, 1'b0, 4'd5, 4'd0,  20'h02000, 1'b0, 1'b1}, // R6 same cycle old key
        '{1'b0, 9'd0,   4'd0,  1'b1, 1'b0, 4'd5, 4'd0,  20'h02000, 1'b1, 1'b0}, // R6 new key seen
        '{1'b1, 9'd4,   4'd15, 1'b0, 1'b0, 4'd0, 4'd0,  20'h00000, 1'b0, 1'b0}, // R8
        '{1'b0, 9'd0,   4'd0,  1'b1, 1'b1, 4'd0, 4'd15, 20'h027FF, 1'b1, 1'b0}, // R7 low bits
        '{1'b0, 9'd0,   4'd0,  1'b1, 1'b0, 4'd1, 4'd0,  20'hFFFFF, 1'b0, 1'b1}  // R7 top block
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        set_valid = 1'b0; set_block = '0; set_key = '0;
        req_valid = 1'b0; req_src = 1'b0; cpu_key = '0; chan_key = '0; req_addr = '0;
    endtask

    task automatic step(input vec_t v);
        @(negedge clk);
        set_valid = v.sv; set_block = v.sb; set_key = v.sk;
        req_valid = v.rv; req_src = v.src; cpu_key = v.ck; chan_key = v.hk; req_addr = v.addr;
        @(posedge clk); #1;
    endtask

    initial begin
        #100000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        logic [ADDR_W-1:0] last_exc = '0;
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 store_en", 32'(store_en), 32'd0);
        check("R1 prot_exc", 32'(prot_exc), 32'd0);
        check("R1 exc_addr", 32'(exc_addr), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            step(VECS[i]);
            if (VECS[i].exc) last_exc = VECS[i].addr;
            check($sformatf("R3/R4 vec%0d store_en", i), 32'(store_en), 32'(VECS[i].en));
            check($sformatf("R4 vec%0d prot_exc", i), 32'(prot_exc), 32'(VECS[i].exc));
            check($sformatf("R4 vec%0d exc_addr", i), 32'(exc_addr), 32'(last_exc));
        end

        // R8: the exception pulse lasts only one cycle
        step('0);
        check("R8 exc pulse ends", 32'(prot_exc), 32'd0);
        check("R8 store_en idle", 32'(store_en), 32'd0);

        // R9: no verdict before the capturing edge
        @(negedge clk);
        req_valid = 1'b1; cpu_key = 4'd0; req_addr = 20'h00100;
        #1;
        check("R9 same cycle", 32'(store_en), 32'd0);
        @(posedge clk); #1;
        check("R9 next cycle", 32'(store_en), 32'd1);

        // R1: reset clears block keys (block 3 held key 5)
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step('{1'b0, 9'd0, 4'd0, 1'b1, 1'b0, 4'd5, 4'd0, 20'h01800, 1'b0, 1'b1});
        check("R1 key cleared", 32'(prot_exc), 32'd1);
        check("R1 key cleared addr", 32'(exc_addr), 32'h01800);

        @(negedge clk);
        idle_inputs();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule